// File: doc/BRIEF.md
# Hardware Reset Pulse Qualifier

This block sits behind the active-low external reset pin of a storage device. It samples the pin with a free-running clock of known period and passes it through a synchronizer. It then drops any pulse of either polarity that is too short to be real, and lets through only level changes that persist.

A qualified low pulse does nothing while the pin is low. The internal reset is issued on the rising edge that ends the pulse, as a single sampling-clock pulse. In that same cycle two gates close. The command-accept enable stays closed for a fixed minimum time. The init-clock flag stays closed until a set number of bus clock rising edges have been seen.

All thresholds are parameters: the sampling period, the longest glitch to reject, the command holdoff and the bus clock count. Pulses longer than the glitch limit but shorter than the guaranteed detection width are treated as qualified once they outlast the stable-level filter. That is a choice made for this design. When the sampling logic comes out of power-on reset, the holdoff and the init-clock count are taken as already satisfied.

Top module: `hwrst_qualifier`

## Requirements
- R1: After power-on reset is released, with the pin held high, `rst_pulse_o` is 0 and both `cmd_en_o` and `init_done_o` are 1.
- R2: A low pulse of 5 ns or less on a high pin produces no internal reset pulse and leaves `cmd_en_o` and `init_done_o` at 1, whatever its phase relative to the sampling clock.
- R3: While the pin is held low, a high pulse of 5 ns or less produces no internal reset pulse. The rising edge that later ends the low period still produces exactly one.
- R4: A low pulse of 1 us or longer produces no reset pulse while the pin is low. It produces exactly one reset pulse, one sampling cycle wide, within 8 sampling cycles after the pin rises.
- R5: A low pulse longer than the filter window but shorter than 1 us (40 ns here) is qualified and produces one reset pulse on its rising edge.
- R6: `cmd_en_o` falls in the same cycle as the reset pulse and stays 0 for exactly ceil(CMD_WAIT_NS*1000/CLK_PERIOD_PS) sampling cycles, counting the pulse cycle.
- R7: `init_done_o` falls in the same cycle as the reset pulse. It is still 0 after INIT_CLKS-1 bus clock rising edges and is 1 after INIT_CLKS edges.
- R8: A qualified reset pulse that arrives while the command holdoff is running restarts the holdoff from the full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running sampling clock of period CLK_PERIOD_PS |
| rst_ni | input | 1 | Power-on reset of the sampling logic, active low |
| rst_pin_ni | input | 1 | External reset pin, active low, asynchronous |
| bus_clk_i | input | 1 | Host bus clock, slower than half the sampling clock |
| rst_pulse_o | output | 1 | Internal reset, one sampling cycle wide |
| cmd_en_o | output | 1 | High when commands may be accepted |
| init_done_o | output | 1 | High once enough bus clocks have been seen since reset |

## Verification
The checker confirms on every cycle that the reset pulse is one cycle wide and that it is preceded by three high synchronized samples of the pin. It also confirms that the two gates close only together with the pulse, and that the init flag, once set, can only drop through a new qualified edge.

Other properties depend on pin timing that a property cannot see. These are left to the bench's scenarios:
- rejecting glitches at different clock phases;
- accepting intermediate pulses;
- the exact holdoff length;
- the bus-clock count threshold;
- restarting the holdoff.

// File: rtl/hwrst_pkg.sv
`timescale 1ns/1ps
package hwrst_pkg;
  // Round-up integer division for cycle counts derived from times.
  function automatic int ceil_div(int num, int den);
    return (num + den - 1) / den;
  endfunction

  // A glitch of glitch_ps can occupy at most glitch_ps/period_ps + 1 samples;
  // require one more consecutive sample than that before accepting a level.
  function automatic int filt_len(int glitch_ps, int period_ps);
    return glitch_ps / period_ps + 2;
  endfunction
endpackage

// File: rtl/hwrst_sync.sv
`timescale 1ns/1ps
module hwrst_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hwrst_filter.sv
`timescale 1ns/1ps
module hwrst_filter #(
  parameter int FILT_CYC = 3,
  parameter int CW       = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  output logic rise_o
);
  logic [CW-1:0] run_q;
  logic          lvl_q;
  logic          differs;
  logic          accept;

  assign differs = pin_s_i ^ lvl_q;
  assign accept  = differs && (run_q == CW'(FILT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      lvl_q <= 1'b1;
    end else if (!differs) begin
      run_q <= '0;
    end else if (accept) begin
      run_q <= '0;
      lvl_q <= pin_s_i;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  // Qualified low-to-high transition of the filtered level.
  assign rise_o = accept && pin_s_i;
endmodule

// File: rtl/hwrst_seq.sv
`timescale 1ns/1ps
module hwrst_seq #(
  parameter int WAIT_CYC  = 50000,
  parameter int INIT_CLKS = 74,
  parameter int WW        = 16,
  parameter int IW        = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic bclk_s_i,
  output logic rst_pulse_o,
  output logic cmd_en_o,
  output logic init_done_o
);
  logic          pulse_q;
  logic          bclk_d;
  logic          bclk_edge;
  logic [WW-1:0] wait_q;
  logic [IW-1:0] init_q;

  assign bclk_edge = bclk_s_i & ~bclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      bclk_d  <= 1'b0;
      wait_q  <= WW'(WAIT_CYC);
      init_q  <= IW'(INIT_CLKS);
    end else begin
      pulse_q <= rise_i;
      bclk_d  <= bclk_s_i;
      if (rise_i)                      wait_q <= '0;
      else if (wait_q != WW'(WAIT_CYC)) wait_q <= wait_q + 1'b1;
      if (rise_i)                                       init_q <= '0;
      else if (bclk_edge && (init_q != IW'(INIT_CLKS))) init_q <= init_q + 1'b1;
    end
  end

  assign rst_pulse_o = pulse_q;
  assign cmd_en_o    = (wait_q == WW'(WAIT_CYC));
  assign init_done_o = (init_q == IW'(INIT_CLKS));
endmodule

// File: rtl/hwrst_qualifier.sv
`timescale 1ns/1ps
module hwrst_qualifier import hwrst_pkg::*; #(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int GLITCH_PS     = 5000,
  parameter int CMD_WAIT_NS   = 200000,
  parameter int INIT_CLKS     = 74,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_pin_ni,
  input  logic bus_clk_i,
  output logic rst_pulse_o,
  output logic cmd_en_o,
  output logic init_done_o
);
  localparam int FILT_CYC = filt_len(GLITCH_PS, CLK_PERIOD_PS);
  localparam int WAIT_CYC = ceil_div(CMD_WAIT_NS * 1000, CLK_PERIOD_PS);
  localparam int FW       = $clog2(FILT_CYC + 1);
  localparam int WW       = $clog2(WAIT_CYC + 1);
  localparam int IW       = $clog2(INIT_CLKS + 1);

  logic pin_s;
  logic bclk_s;
  logic rise_evt;

  hwrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rst_pin_ni), .q_o(pin_s)
  );

  hwrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bclk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_clk_i), .q_o(bclk_s)
  );

  hwrst_filter #(.FILT_CYC(FILT_CYC), .CW(FW)) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_s_i(pin_s), .rise_o(rise_evt)
  );

  hwrst_seq #(.WAIT_CYC(WAIT_CYC), .INIT_CLKS(INIT_CLKS), .WW(WW), .IW(IW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise_evt), .bclk_s_i(bclk_s),
    .rst_pulse_o(rst_pulse_o), .cmd_en_o(cmd_en_o), .init_done_o(init_done_o)
  );
endmodule

// File: rtl/hwrst_qualifier_chk.sv
`timescale 1ns/1ps
module hwrst_qualifier_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pin_s,
  input logic rise_evt,
  input logic rst_pulse,
  input logic cmd_en,
  input logic init_done
);
  // R4: internal reset is a single sampling-cycle pulse.
  assert_pulse_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse |=> !rst_pulse);

  // R2, R3: a pulse needs three consecutive high synchronized samples
  // (holds for the default filter length of three).
  assert_pulse_filtered_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse |-> ($past(pin_s, 1) && $past(pin_s, 2) && $past(pin_s, 3)));

  // R6: command enable closes together with the reset pulse.
  assert_cmd_closed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse |-> !cmd_en);

  assert_cmd_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_en) |-> rst_pulse);

  // R7: init flag closes with the pulse and only a new edge can clear it.
  assert_init_closed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse |-> !init_done);

  assert_init_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done && !rise_evt) |=> init_done);
endmodule

bind hwrst_qualifier hwrst_qualifier_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pin_s(pin_s), .rise_evt(rise_evt),
  .rst_pulse(rst_pulse_o), .cmd_en(cmd_en_o), .init_done(init_done_o)
);

// File: tb/hwrst_qualifier_bench.sv
`timescale 1ns/1ps
module hwrst_qualifier_bench;
  // 2 us holdoff at a 4 ns sampling period -> 500 cycles.
  localparam int EXP_WAIT  = 500;
  localparam int EXP_INIT  = 74;
  localparam int MAX_LAT   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_n = 1'b1;
  logic bclk = 1'b0;
  logic rst_pulse, cmd_en, init_done;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit prev_pulse = 1'b0;
  string exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hwrst_qualifier #(.CMD_WAIT_NS(2000)) u_hwrst_qualifier (
    .clk_i(clk), .rst_ni(rst_n), .rst_pin_ni(pin_n), .bus_clk_i(bclk),
    .rst_pulse_o(rst_pulse), .cmd_en_o(cmd_en), .init_done_o(init_done)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_pulse(string req);
    exp_q.push_back(req);
  endtask

  // Monitor: pops one expected item for each reset pulse it observes.
  always @(negedge clk) begin
    if (rst_n && rst_pulse) begin
      string r;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R3/R4", "unexpected reset pulse", 1, 0);
      end else begin
        r = exp_q.pop_front();
        chk(!prev_pulse, r, "pulse wider than one cycle", 2, 1);
        chk(cmd_en == 1'b0, "R6", "cmd_en at pulse", cmd_en, 0);
        chk(init_done == 1'b0, "R7", "init_done at pulse", init_done, 0);
      end
    end
    prev_pulse = rst_n && rst_pulse;
  end

  task automatic wait_pulse(string req, int rise_cyc);
    int n = 0;
    while (!rst_pulse && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(rst_pulse && (cyc - rise_cyc) >= 1 && (cyc - rise_cyc) <= MAX_LAT,
        req, "pulse latency after rise", cyc - rise_cyc, MAX_LAT);
  endtask

  task automatic count_cmd_low(string req);
    int n = 0;
    while (!cmd_en && n < EXP_WAIT + 20) begin
      n++;
      @(negedge clk);
    end
    chk(n == EXP_WAIT, req, "cmd_en low cycles", n, EXP_WAIT);
  endtask

  task automatic low_pulse(int cycles_low);
    @(posedge clk); #1 pin_n = 1'b0;
    repeat (cycles_low) @(posedge clk);
    #1 pin_n = 1'b1;
  endtask

  task automatic drain_queue(string req);
    chk(exp_q.size() == 0, req, "missing expected pulses", exp_q.size(), 0);
  endtask

  initial begin
    int rc;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(rst_pulse == 1'b0, "R1", "rst_pulse after por", rst_pulse, 0);
    chk(cmd_en == 1'b1, "R1", "cmd_en after por", cmd_en, 1);
    chk(init_done == 1'b1, "R1", "init_done after por", init_done, 1);

    // R2: short low glitches at two phases and a shorter one
    @(posedge clk); #1   pin_n = 1'b0; #5 pin_n = 1'b1;
    @(posedge clk); #3.5 pin_n = 1'b0; #5 pin_n = 1'b1;
    @(posedge clk); #0.5 pin_n = 1'b0; #3 pin_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(cmd_en == 1'b1, "R2", "cmd_en after glitches", cmd_en, 1);
    chk(init_done == 1'b1, "R2", "init_done after glitches", init_done, 1);
    drain_queue("R2");

    // R4, R6, R7: 1 us low pulse, then holdoff and bus clock count
    @(posedge clk); #1 pin_n = 1'b0;
    repeat (250) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0 && cmd_en == 1'b1, "R4", "no effect while low", cmd_en, 1);
    expect_pulse("R4");
    @(posedge clk); #1 pin_n = 1'b1; rc = cyc;
    wait_pulse("R4", rc);
    fork
      count_cmd_low("R6");
      begin
        for (int i = 1; i <= EXP_INIT; i++) begin
          @(posedge clk); #1 bclk = 1'b1;
          repeat (4) @(posedge clk);
          #1 bclk = 1'b0;
          repeat (3) @(posedge clk);
          @(negedge clk);
          if (i == EXP_INIT - 1)
            chk(init_done == 1'b0, "R7", "init_done after 73 edges", init_done, 0);
          if (i == EXP_INIT)
            chk(init_done == 1'b1, "R7", "init_done after 74 edges", init_done, 1);
        end
      end
    join
    drain_queue("R4");

    // R3: high glitch while low, then a real rise
    @(posedge clk); #1 pin_n = 1'b0;
    repeat (150) @(posedge clk);
    #1 pin_n = 1'b1; #4 pin_n = 1'b0;
    repeat (150) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0 && cmd_en == 1'b1, "R3", "high glitch ignored", cmd_en, 1);
    expect_pulse("R3");
    @(posedge clk); #1 pin_n = 1'b1; rc = cyc;
    wait_pulse("R3", rc);
    count_cmd_low("R3");

    // R5: 40 ns intermediate pulse qualifies
    expect_pulse("R5");
    low_pulse(10); rc = cyc;
    wait_pulse("R5", rc);
    count_cmd_low("R5");

    // R8: a second reset during the holdoff restarts it
    expect_pulse("R8");
    low_pulse(250); rc = cyc;
    wait_pulse("R8", rc);
    repeat (200) @(negedge clk);
    chk(cmd_en == 1'b0, "R8", "cmd_en mid holdoff", cmd_en, 0);
    expect_pulse("R8");
    low_pulse(250); rc = cyc;
    wait_pulse("R8", rc);
    count_cmd_low("R8");
    repeat (10) @(negedge clk);
    drain_queue("R8");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule